// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit turns a 32-bit logical address into a physical address using 4 KB pages. The low twelve bits select a byte within the page and pass through unchanged. The next eleven bits select one of 2048 page-table entries. Each entry holds a present flag and a 20-bit frame number. The physical address is the frame number placed directly above the byte offset, so no multiplier is needed.

An eight-entry fully associative translation cache sits in front of the table. A request is accepted with a valid/ready handshake. When the page is cached, the translated address appears one cycle after acceptance. When it is not cached, the unit issues a single read to an external page-table port that has variable latency. It then responds, and it caches the mapping if the entry is present. An entry that is not present ends the request with a fault indication. Only one translation is outstanding at a time. A flush input empties the cache.

Top module: `page_xlat`

## Requirements
- R1: A successful response carries `rsp_paddr = {frame, vaddr[11:0]}`. For example, page 1027 mapped to frame 57 turns 0x00403A9C into 0x00039A9C.
- R2: The page-table read index `pt_req_idx` is `vaddr[22:12]`. In `pt_rsp_data`, bit 20 is the present flag and bits 19:0 are the frame number.
- R3: When the page is cached, `rsp_valid` rises in the cycle after the request is accepted, and no page-table read is issued.
- R4: When the page is not cached, exactly one page-table read is issued. The response follows the cycle after `pt_rsp_valid`. A present entry is cached, so the next access to that page makes no read.
- R5: An entry that is not present gives `rsp_fault = 1` and `rsp_paddr = 0xFFFFFFFF`. Nothing is cached, so a repeated access reads the table again.
- R6: A logical address with any of bits 31:23 set lies beyond the table. It faults (all-ones address) one cycle after acceptance and issues no page-table read.
- R7: `req_ready` is high in idle. It stays low from the acceptance of an uncached request until its response cycle.
- R8: `pt_req_valid` and `pt_req_idx` hold steady until `pt_req_ready` accepts the read.
- R9: A refill goes to the lowest-numbered empty cache entry. When all eight entries are full, it goes to a round-robin victim pointer that starts at entry 0, advances once per eviction, and returns to 0 on flush.
- R10: `flush` empties the whole cache in one cycle and wins over a refill in the same cycle. The response of that refill is still delivered, but the mapping is not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the translation cache |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Logical address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Page fault indication |
| rsp_paddr | output | 32 | Physical address, all ones on fault |
| pt_req_valid | output | 1 | Page-table read request |
| pt_req_ready | input | 1 | Page-table read accepted |
| pt_req_idx | output | 11 | Page-table entry index |
| pt_rsp_valid | input | 1 | Page-table read data present |
| pt_rsp_data | input | 21 | Entry: present flag at bit 20, frame at 19:0 |

## Verification
The assertions assume that the page-table port returns exactly one `pt_rsp_valid` pulse per accepted read, and only after that read has been accepted. They also assume that `pt_rsp_valid` never arrives unsolicited. The bench memory model enforces this by construction: it raises data only after it has granted a read, and it raises it once. The model also stalls the read grant and the data return by different numbers of cycles, so the index-hold and ready-low properties are exercised over multi-cycle windows.

// File: rtl/page_xlat_pkg.sv
package page_xlat_pkg;
  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_REQ  = 2'd1,
    WK_WAIT = 2'd2
  } walk_state_e;
endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int N      = 8,
  parameter int TAG_W  = 11,
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      vld_q;
  logic [TAG_W-1:0]  tag_q [N];
  logic [DATA_W-1:0] dat_q [N];
  logic [IW-1:0]     rr_q;
  logic [N-1:0]      hit_vec;
  logic              free_found;
  logic [IW-1:0]     free_idx;
  logic [IW-1:0]     victim;
  logic              fill_go;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  assign lk_hit = |hit_vec;

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) lk_data = lk_data | dat_q[i];
    end
  end

  // lowest-numbered empty slot wins
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
    end
  end

  assign victim  = free_found ? free_idx : rr_q;
  assign fill_go = fill_en && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (fill_en) begin
      vld_q[victim] <= 1'b1;
      if (!free_found) rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[victim] <= fill_tag;
      dat_q[victim] <= fill_data;
    end
  end

  // R9: a page is never cached in two slots
  p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R10: flush leaves the cache empty even if a refill was requested
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import page_xlat_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int PN_W  = 11,
  parameter int FR_W  = 20,
  localparam int PA_W  = FR_W + OFF_W,
  localparam int PTE_W = FR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OFF_W-1:0] in_off,
  input  logic [PN_W-1:0]  in_pn,
  input  logic             in_range,
  input  logic             tlb_hit,
  input  logic [FR_W-1:0]  tlb_frame,
  output logic             pt_req_valid,
  input  logic             pt_req_ready,
  output logic [PN_W-1:0]  pt_req_idx,
  input  logic             pt_rsp_valid,
  input  logic [PTE_W-1:0] pt_rsp_data,
  output logic             fill_en,
  output logic [PN_W-1:0]  fill_tag,
  output logic [FR_W-1:0]  fill_frame,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr
);
  function automatic logic [PA_W-1:0] join_pa(input logic [FR_W-1:0] frame,
                                              input logic [OFF_W-1:0] off);
    return {frame, off};
  endfunction

  walk_state_e      state_q;
  logic [PN_W-1:0]  pn_q;
  logic [OFF_W-1:0] off_q;

  logic             req_fire;
  logic             hit_fire;
  logic             miss_fire;
  logic             range_fault_fire;
  logic             pte_ok;
  logic [FR_W-1:0]  pte_frame;
  logic             rsp_take;

  assign req_ready        = (state_q == WK_IDLE);
  assign req_fire         = req_valid && req_ready;
  assign range_fault_fire = req_fire && !in_range;
  assign hit_fire         = req_fire && in_range && tlb_hit;
  assign miss_fire        = req_fire && in_range && !tlb_hit;

  assign pte_ok    = pt_rsp_data[PTE_W-1];
  assign pte_frame = pt_rsp_data[FR_W-1:0];
  assign rsp_take  = (state_q == WK_WAIT) && pt_rsp_valid;

  assign pt_req_valid = (state_q == WK_REQ);
  assign pt_req_idx   = pn_q;
  assign fill_en      = rsp_take && pte_ok;
  assign fill_tag     = pn_q;
  assign fill_frame   = pte_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= WK_IDLE;
      pn_q      <= '0;
      off_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        WK_IDLE: begin
          if (range_fault_fire) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_paddr <= '1;
          end else if (hit_fire) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_paddr <= join_pa(tlb_frame, in_off);
          end else if (miss_fire) begin
            pn_q    <= in_pn;
            off_q   <= in_off;
            state_q <= WK_REQ;
          end
        end
        WK_REQ: begin
          if (pt_req_ready) state_q <= WK_WAIT;
        end
        WK_WAIT: begin
          if (rsp_take) begin
            rsp_valid <= 1'b1;
            rsp_fault <= !pte_ok;
            rsp_paddr <= pte_ok ? join_pa(pte_frame, off_q) : '1;
            state_q   <= WK_IDLE;
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  // R3: a cached page answers on the next cycle without fault
  p_hit_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> (rsp_valid && !rsp_fault));

  // R7: an uncached request blocks further requests
  p_miss_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire |=> (!req_ready && !rsp_valid));

  // R8: read request held until accepted
  p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_req_valid && !pt_req_ready) |=> (pt_req_valid && $stable(pt_req_idx)));

  // R5: faults carry an all-ones address
  p_fault_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == {PA_W{1'b1}}));

  // R6: out-of-table addresses fault on the next cycle
  p_range_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    range_fault_fire |=> (rsp_valid && rsp_fault));
endmodule

// File: rtl/page_xlat.sv
module page_xlat #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PN_W  = 11,
  parameter int TLB_N = 8,
  localparam int FR_W  = PA_W - OFF_W,
  localparam int PTE_W = FR_W + 1,
  localparam int HI_W  = VA_W - OFF_W - PN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             pt_req_valid,
  input  logic             pt_req_ready,
  output logic [PN_W-1:0]  pt_req_idx,
  input  logic             pt_rsp_valid,
  input  logic [PTE_W-1:0] pt_rsp_data
);
  function automatic logic [PN_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[OFF_W +: PN_W];
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  logic [PN_W-1:0]  in_pn;
  logic [OFF_W-1:0] in_off;
  logic             in_range;
  logic             tlb_hit;
  logic [FR_W-1:0]  tlb_frame;
  logic             fill_en;
  logic [PN_W-1:0]  fill_tag;
  logic [FR_W-1:0]  fill_frame;
  logic [OFF_W-1:0] off_track_q;

  assign in_pn  = page_of(req_vaddr);
  assign in_off = offset_of(req_vaddr);

  if (HI_W > 0) begin : g_range
    assign in_range = ~|req_vaddr[VA_W-1:OFF_W+PN_W];
  end else begin : g_full
    assign in_range = 1'b1;
  end

  xlat_tlb #(
    .N      (TLB_N),
    .TAG_W  (PN_W),
    .DATA_W (FR_W)
  ) u_tlb (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lk_tag    (in_pn),
    .lk_hit    (tlb_hit),
    .lk_data   (tlb_frame),
    .fill_en   (fill_en),
    .fill_tag  (fill_tag),
    .fill_data (fill_frame)
  );

  xlat_walker #(
    .OFF_W (OFF_W),
    .PN_W  (PN_W),
    .FR_W  (FR_W)
  ) u_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .in_off       (in_off),
    .in_pn        (in_pn),
    .in_range     (in_range),
    .tlb_hit      (tlb_hit),
    .tlb_frame    (tlb_frame),
    .pt_req_valid (pt_req_valid),
    .pt_req_ready (pt_req_ready),
    .pt_req_idx   (pt_req_idx),
    .pt_rsp_valid (pt_rsp_valid),
    .pt_rsp_data  (pt_rsp_data),
    .fill_en      (fill_en),
    .fill_tag     (fill_tag),
    .fill_frame   (fill_frame),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_paddr    (rsp_paddr)
  );

  // offset of the most recently accepted request, kept for checking only
  always_ff @(posedge clk) begin
    if (!rst_n) off_track_q <= '0;
    else if (req_valid && req_ready) off_track_q <= in_off;
  end

  // R1: the byte offset survives translation
  p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == off_track_q));

  // R5: a faulting walk never installed a mapping
  p_no_fill_on_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> !$past(fill_en));
endmodule

// File: tb/page_xlat_bench.sv
module page_xlat_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        flush_main;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [31:0] rsp_paddr;
  logic        pt_req_valid;
  logic        pt_req_ready;
  logic [10:0] pt_req_idx;
  logic        pt_rsp_valid;
  logic [20:0] pt_rsp_data;

  int total = 0;
  int bad = 0;
  int walks = 0;
  int mem_lat = 1;
  int mem_gap = 0;
  bit flush_on_rsp = 1'b0;
  bit finished = 1'b0;
  logic [10:0] seen_idx;
  logic [10:0] idx0;
  bit hold_ok;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign flush = flush_main | (flush_on_rsp & pt_rsp_valid);

  page_xlat u_page_xlat (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_paddr    (rsp_paddr),
    .pt_req_valid (pt_req_valid),
    .pt_req_ready (pt_req_ready),
    .pt_req_idx   (pt_req_idx),
    .pt_rsp_valid (pt_rsp_valid),
    .pt_rsp_data  (pt_rsp_data)
  );

  // page-table contents: low nibble F means not present; page 1027 -> frame 57
  function automatic bit ref_present(input logic [10:0] idx);
    return idx[3:0] != 4'hF;
  endfunction

  function automatic logic [19:0] ref_frame(input logic [10:0] idx);
    logic [19:0] f;
    if (idx == 11'd1027) return 20'd57;
    f = {9'd0, idx};
    return f * 20'd97 + 20'd3;
  endfunction

  function automatic logic [31:0] ref_paddr(input logic [31:0] va);
    if (va[31:23] != 9'd0) return 32'hFFFF_FFFF;
    if (!ref_present(va[22:12])) return 32'hFFFF_FFFF;
    return {ref_frame(va[22:12]), va[11:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  // page-table memory model with variable grant and data delay
  initial begin
    pt_req_ready = 1'b0;
    pt_rsp_valid = 1'b0;
    pt_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (pt_req_valid) begin
        idx0 = pt_req_idx;
        hold_ok = 1'b1;
        repeat (mem_gap) begin
          @(negedge clk);
          if (!pt_req_valid || pt_req_idx !== idx0) hold_ok = 1'b0;
        end
        pt_req_ready = 1'b1;
        @(negedge clk);
        pt_req_ready = 1'b0;
        walks++;
        seen_idx = idx0;
        chk(hold_ok, "R8 index held while stalled", {21'd0, pt_req_idx}, {21'd0, idx0});
        repeat (mem_lat) @(negedge clk);
        pt_rsp_valid = 1'b1;
        pt_rsp_data  = {ref_present(idx0), ref_frame(idx0)};
        @(negedge clk);
        pt_rsp_valid = 1'b0;
      end
    end
  end

  task automatic translate(input logic [31:0] va, output logic [31:0] pa,
                           output logic flt, output int waited, output bit leak);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    leak = 1'b0;
    while (!rsp_valid && waited < 5000) begin
      if (req_ready) leak = 1'b1;
      waited++;
      @(negedge clk);
    end
    pa  = rsp_paddr;
    flt = rsp_fault;
  endtask

  task automatic run_one(input logic [31:0] va, input int exp_walks, input string tag);
    logic [31:0] pa;
    logic flt;
    int waited;
    bit leak;
    int w0;
    logic [31:0] exp_pa;
    w0 = walks;
    translate(va, pa, flt, waited, leak);
    exp_pa = ref_paddr(va);
    chk(pa == exp_pa, {tag, " R1 address"}, pa, exp_pa);
    chk(flt == (exp_pa == 32'hFFFF_FFFF), {tag, " R5 fault flag"}, {31'd0, flt},
        {31'd0, exp_pa == 32'hFFFF_FFFF});
    chk((walks - w0) == exp_walks, {tag, " R4 table reads"}, 32'(walks - w0), 32'(exp_walks));
    if (exp_walks == 0)
      chk(waited == 0, {tag, " R3 one-cycle answer"}, 32'(waited), 32'd0);
    else begin
      chk(!leak, {tag, " R7 ready low during walk"}, {31'd0, leak}, 32'd0);
      chk(seen_idx == va[22:12], {tag, " R2 table index"}, {21'd0, seen_idx},
          {21'd0, va[22:12]});
    end
  endtask

  function automatic logic [31:0] va_of(input logic [10:0] pg, input logic [11:0] off);
    return {9'd0, pg, off};
  endfunction

  // {logical address, expected page-table reads}
  localparam logic [33:0] VEC [NVEC] = '{
    {32'h0040_3A9C, 2'd1},
    {32'h0040_3000, 2'd0},
    {32'h0040_3FFF, 2'd0},
    {32'h0002_F123, 2'd1},
    {32'h0002_F000, 2'd1},
    {32'h0080_0000, 2'd0},
    {32'hFFFF_F001, 2'd0},
    {32'h007F_F555, 2'd1},
    {32'h007F_E010, 2'd1},
    {32'h007F_E777, 2'd0},
    {32'h0000_0ABC, 2'd1},
    {32'h0000_0001, 2'd0}
  };

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R7 act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    flush_main = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 reset ready", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid == 1'b0, "R3 reset no response", {31'd0, rsp_valid}, 32'd0);
    chk(pt_req_valid == 1'b0, "R4 reset no read", {31'd0, pt_req_valid}, 32'd0);

    // table walk: R1 R2 R3 R4 R5 R6 patterns
    for (int i = 0; i < NVEC; i++) begin
      mem_lat = i % 3;
      mem_gap = (i * 2) % 5;
      run_one(VEC[i][33:2], int'(VEC[i][1:0]), "vec");
    end

    // R10: plain flush forces a re-read
    mem_lat = 2;
    mem_gap = 1;
    @(negedge clk);
    flush_main = 1'b1;
    @(negedge clk);
    flush_main = 1'b0;
    run_one(32'h0040_3A9C, 1, "R10 after flush");
    run_one(32'h0040_3A9C, 0, "R10 refilled");

    // R10: flush in the refill cycle wins
    flush_on_rsp = 1'b1;
    run_one(va_of(11'h030, 12'hABC), 1, "R10 flush vs refill");
    flush_on_rsp = 1'b0;
    run_one(va_of(11'h030, 12'h123), 1, "R10 mapping dropped");

    // R9: fill order and round-robin eviction
    @(negedge clk);
    flush_main = 1'b1;
    @(negedge clk);
    flush_main = 1'b0;
    for (int p = 0; p < 9; p++) run_one(va_of(11'h100 + 11'(p), 12'h010), 1, "R9 fill");
    for (int p = 1; p < 8; p++) run_one(va_of(11'h100 + 11'(p), 12'h020), 0, "R9 survivors hit");
    run_one(va_of(11'h100, 12'h030), 1, "R9 slot0 evicted");
    run_one(va_of(11'h101, 12'h040), 1, "R9 slot1 evicted");
    run_one(va_of(11'h108, 12'h050), 0, "R9 slot0 holder");
    run_one(va_of(11'h102, 12'h060), 1, "R9 slot2 evicted");

    summary();
    $finish;
  end
endmodule